// File: doc/BRIEF.md
# Fifteen-Cent Coin Vending Controller

A small synchronous controller that takes coins one per clock cycle and releases a drink once the money deposited adds up to fifteen cents. It accepts nickels (5 cents) and dimes (10 cents). Any other coin, including a quarter, is refused. Credit is held internally in 5-cent steps, so the controller is always at 0, 5 or 10 cents.

Coins arrive on three strobes: nickel, dime and bad coin. The outputs follow the coin event in the same cycle, Mealy style. The outputs are a reject pulse, a dispense pulse and a nickel-change pulse. A dime inserted at 10 cents overpays by one nickel. That cycle raises dispense and change together. After every dispense the credit goes back to zero.

Top module: `vend15`

## Requirements
- R1: With reset (`rst`, synchronous, active high) asserted, the credit goes to zero. With no coin strobe active, all three outputs are low.
- R2: In a cycle with no coin strobe, all outputs are low and the credit is unchanged.
- R3: Three nickels in a row from zero credit dispense on the third nickel only, with no change.
- R4: A dime at zero credit followed by a nickel dispenses on the nickel, with no change.
- R5: A nickel at zero credit followed by a dime dispenses on the dime, with no change.
- R6: A dime at 10 cents credit raises `vend` and `change_nickel` together in that cycle.
- R7: A bad coin raises `reject` for that cycle only. It leaves the credit unchanged and never coincides with `vend` or `change_nickel`.
- R8: Nickel and dime strobes together in one cycle are treated as a bad coin: `reject` is high and nothing is credited.
- R9: Every output is a pulse lasting only the cycle of its coin. After a dispense the credit is zero, so a later sale needs a full 15 cents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_nickel | input | 1 | A 5-cent coin arrives this cycle |
| coin_dime | input | 1 | A 10-cent coin arrives this cycle |
| coin_bad | input | 1 | An invalid coin arrives this cycle |
| reject | output | 1 | Return the coin presented this cycle |
| vend | output | 1 | Dispense one drink this cycle |
| change_nickel | output | 1 | Return one nickel of change this cycle |

## Verification
The bench targets the overpay case: a dime at 10 cents. A design that drops the change would sell at 20 cents. A design that keeps the surplus nickel as credit would hand out a cheap next drink. The bench also puts bad coins and doubled strobes between valid coins. A design that credited them, or lost the credit already held, would dispense one coin early or one coin late. The third check is a full sale right after a dispense. It catches a design that leaves the credit set to anything but zero.

// File: rtl/vend15.sv
module vend15 #(
  parameter int NICKEL = 5,
  parameter int DIME   = 10,
  parameter int PRICE  = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic coin_nickel,
  input  logic coin_dime,
  input  logic coin_bad,
  output logic reject,
  output logic vend,
  output logic change_nickel
);
  localparam int STEPS = PRICE / NICKEL;
  localparam int DSTEP = DIME / NICKEL;
  localparam int CW    = $clog2(STEPS + DSTEP);

  logic [CW-1:0] credit_q;
  logic [CW-1:0] sum;
  logic          invalid, valid, full;

  assign invalid       = coin_bad | (coin_nickel & coin_dime);
  assign valid         = ~invalid & (coin_nickel | coin_dime);
  assign sum           = credit_q + (coin_dime ? CW'(DSTEP) : CW'(1));
  assign full          = valid && (sum >= CW'(STEPS));
  assign reject        = invalid;
  assign vend          = full;
  assign change_nickel = full && (sum != CW'(STEPS));

  always_ff @(posedge clk) begin
    if (rst)        credit_q <= '0;
    else if (valid) credit_q <= full ? '0 : sum;
  end
endmodule

module vend15_chk #(parameter int CW = 3) (
  input logic          clk,
  input logic          rst,
  input logic          coin_nickel,
  input logic          coin_dime,
  input logic          coin_bad,
  input logic          reject,
  input logic          vend,
  input logic          change_nickel,
  input logic [CW-1:0] credit_q
);
  AST_CHANGE_WITH_VEND: assert property (@(posedge clk) disable iff (rst)
    change_nickel |-> vend); // R6
  AST_REJECT_ALONE: assert property (@(posedge clk) disable iff (rst)
    reject |-> (!vend && !change_nickel)); // R7
  AST_REJECT_KEEPS_CREDIT: assert property (@(posedge clk) disable iff (rst)
    reject |=> (credit_q == $past(credit_q))); // R7
  AST_DOUBLE_IS_REJECT: assert property (@(posedge clk) disable iff (rst)
    (coin_nickel && coin_dime) |-> (reject && !vend)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!coin_nickel && !coin_dime && !coin_bad) |=> (credit_q == $past(credit_q))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!coin_nickel && !coin_dime && !coin_bad) |-> (!reject && !vend && !change_nickel)); // R2
  AST_VEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    vend |=> (credit_q == '0)); // R9
endmodule

bind vend15 vend15_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .coin_nickel(coin_nickel), .coin_dime(coin_dime),
  .coin_bad(coin_bad), .reject(reject), .vend(vend),
  .change_nickel(change_nickel), .credit_q(credit_q)
);

// File: tb/vend15_bench.sv
module vend15_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_nickel = 1'b0, coin_dime = 1'b0, coin_bad = 1'b0;
  logic reject, vend, change_nickel;

  always #10 clk = ~clk;

  vend15 u_vend15 (
    .clk(clk), .rst(rst), .coin_nickel(coin_nickel), .coin_dime(coin_dime),
    .coin_bad(coin_bad), .reject(reject), .vend(vend), .change_nickel(change_nickel)
  );

  typedef struct {
    logic [2:0] outs;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   tests = 0, fails = 0;
  int   credit = 0;
  bit   done = 1'b0;

  task automatic put(input bit n, input bit d, input bit b, input string tag);
    exp_t e;
    int   add;
    @(negedge clk);
    coin_nickel = n; coin_dime = d; coin_bad = b;
    e.tag = tag;
    e.outs = 3'b000;
    if (b || (n && d)) e.outs = 3'b100;
    else if (n || d) begin
      add = n ? 5 : 10;
      if (credit + add >= 15) begin
        e.outs = {1'b0, 1'b1, (credit + add > 15)};
        credit = 0;
      end else credit = credit + add;
    end
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        tests++;
        if ({reject, vend, change_nickel} !== e.outs) begin
          fails++;
          $display("FAIL %s: {reject,vend,change} actual %b expected %b",
                   e.tag, {reject, vend, change_nickel}, e.outs);
        end
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    put(0, 0, 0, "R1 reset idle");
    @(negedge clk);
    rst = 1'b0;
    put(0, 1, 0, "R1 dime after reset");
    put(1, 0, 0, "R4 nickel completes");
    put(1, 0, 0, "R3 nickel 1");
    put(1, 0, 0, "R3 nickel 2");
    put(0, 0, 0, "R2 idle at 10");
    put(0, 0, 0, "R2 idle again");
    put(1, 0, 0, "R3 nickel 3");
    put(1, 0, 0, "R5 nickel");
    put(0, 1, 0, "R5 dime completes");
    put(0, 1, 0, "R6 dime to 10");
    put(0, 0, 1, "R7 bad at 10");
    put(0, 1, 0, "R6 dime overpay");
    put(1, 0, 0, "R9 fresh sale nickel");
    put(1, 1, 0, "R8 double strobe");
    put(0, 0, 1, "R7 bad at 5");
    put(1, 1, 0, "R8 double again");
    put(1, 0, 0, "R9 nickel to 10");
    put(0, 1, 0, "R6 second overpay");
    put(1, 0, 0, "R9 after change");
    put(0, 0, 0, "R9 pulse ends");
    put(1, 0, 0, "R9 nickel to 10");
    put(1, 0, 0, "R9 dispense clears");
    put(0, 0, 0, "R2 idle at 0");
    @(negedge clk);
    coin_nickel = 0; coin_dime = 0; coin_bad = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule